// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block turns requests from an internal port into bus cycles on external asynchronous SRAM. A request carries a word address, write data, four byte enables, a direction flag and, for reads, a burst length of one to four words. It is accepted with a valid/ready handshake. The upper bits of the word address pick one of six banks, and each bank has its own active-low chip select. Every bank is described by static configuration inputs:
- a 3-bit memory kind
- a read access time
- a write-strobe width
- a bus recovery time
- a flag that selects a 16-bit data path instead of the 32-bit one

Only banks whose kind is SRAM, and whose index is below six, are ever driven. Any other request is accepted and answered with a one-cycle error pulse. It produces no bus activity.

During a read, output enable stays low for the whole burst. Each bus beat lasts the programmed latency plus one cycle, and the address steps from beat to beat. Each completed 32-bit word comes back with a one-cycle valid pulse. During a write, the write strobe is held low for the programmed width. A hold cycle follows, with the strobe high and the chip select still low. On a 16-bit bank every 32-bit word is moved as two halfword beats, low half first. After every access the chip selects stay high for a recovery gap before the port accepts the next request.

Top module: `sram_ctrl_top`

## Requirements
- R1: The request word address is {bank[2:0], word offset[23:0]}. During an access only the chip select of that bank is low (mem_cs_n bit = bank index), for exactly the cycles of the bus beats. A bank index of 6 or 7 is rejected.
- R2: A bank whose kind field is not 3'b001 is rejected. rsp_err is high for exactly one cycle, the cycle after acceptance, and req_ready is high again one cycle later. No chip select, strobe or enable goes low, and the SRAM contents are unchanged.
- R3: mem_oe_n is low only during reads and mem_we_n only during writes. The two are never low together, and neither is low unless a chip select is low.
- R4: While mem_oe_n is low, mem_be_n is 4'b0000.
- R5: While mem_we_n is low, mem_dq_oe is 1. On a 32-bit bank mem_be_n equals the inverted byte enables. On a 16-bit bank mem_be_n[3:2] is 2'b11 and mem_be_n[1:0] carries the inverted enables req_be[1:0] in the first beat, then req_be[3:2] in the second.
- R6: On a bank with read latency field L, each read bus beat lasts L+1 cycles, and mem_oe_n stays low without a break for the whole burst.
- R7: On a bank with write-width field W, mem_we_n is low for W cycles (one cycle when W is 0) in each write beat. One cycle with mem_we_n high and the chip select still low follows each beat.
- R8: On a bank with recovery field R, all chip selects are high for 2R+1 cycles after the last beat, and req_ready then rises.
- R9: req_ready is high when idle. It goes low the cycle after a request is accepted and stays low through the recovery gap.
- R10: A read with req_len = N (0..3) returns N+1 words, taken from consecutive word addresses, in order, each as a one-cycle rsp_valid pulse. rsp_valid and rsp_err are never high together.
- R11: On a 16-bit bank each word is moved in two beats, low half first. The byte address on mem_addr steps by 2 per beat, only mem_dq_i[15:0] is sampled, and read data is rebuilt as {second half, first half}.
- R12: While reset is held and right after it:
  - all chip selects, mem_oe_n and mem_we_n are 1
  - mem_be_n is 4'b1111
  - mem_dq_oe and rsp_valid are 0
  - req_ready is 1

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 27 | Word address {bank, offset} |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| req_len | input | 2 | Read burst length minus one |
| rsp_valid | output | 1 | Read word valid pulse |
| rsp_rdata | output | 32 | Read word |
| rsp_err | output | 1 | Rejected request pulse |
| cfg_kind | input | 6x3 | Per-bank memory kind, 3'b001 = SRAM |
| cfg_rd_lat | input | 6x4 | Per-bank read latency field |
| cfg_wr_wid | input | 6x4 | Per-bank write strobe width field |
| cfg_recov | input | 6x3 | Per-bank recovery field |
| cfg_half_bus | input | 6 | Per-bank 16-bit data path select |
| mem_cs_n | output | 6 | Active-low chip selects |
| mem_addr | output | 26 | Byte address to the memory |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | 4 | Active-low byte selects |
| mem_dq_o | output | 32 | Data driven to the memory |
| mem_dq_oe | output | 1 | Data pins driven |
| mem_dq_i | input | 32 | Data returned by the memory |

## Verification
The embedded properties check the pin rules that hold on every cycle:
- at most one chip select low, and neither enable low without one
- enables mutually exclusive
- all byte selects active while reading
- data driven whenever the write strobe is low
- a hold cycle after each strobe
- the busy drop after acceptance
- a single-cycle error pulse with a quiet bus

Only the bench scenarios can show the quantities that depend on configuration. These are the beat lengths per latency field, the strobe widths, the recovery gap and the total busy time. The bench also shows that burst words come from stepping addresses, and that the halves of a 16-bit bank land in the right order and lanes. Finally, it shows that rejected requests leave memory untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int KIND_W = 3;
    localparam int RDL_W  = 4;
    localparam int WRW_W  = 4;
    localparam int RRR_W  = 3;

    localparam logic [KIND_W-1:0] KIND_SRAM = 3'b001;

    // timer must hold the largest reload: latency, strobe width - 1, or 2*recovery
    localparam int TMR_A = (RDL_W > WRW_W) ? RDL_W : WRW_W;
    localparam int TMR_W = (TMR_A > RRR_W + 1) ? TMR_A : RRR_W + 1;

    typedef struct packed {
        logic [RDL_W-1:0] rd_lat;
        logic [WRW_W-1:0] wr_wid;
        logic [RRR_W-1:0] recov;
        logic             half_bus;
    } bank_timing_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REJECT,
        ST_READ,
        ST_WSTROBE,
        ST_WHOLD,
        ST_RECOVER
    } bus_state_e;

    // strobe low for w cycles, a zero field behaves as one
    function automatic logic [TMR_W-1:0] strobe_reload(input logic [WRW_W-1:0] w);
        logic [TMR_W-1:0] wide;
        wide = TMR_W'(w);
        return (wide == '0) ? '0 : wide - 1'b1;
    endfunction

    // gap of 2r+1 cycles: counter runs 2r down to 0
    function automatic logic [TMR_W-1:0] recover_reload(input logic [RRR_W-1:0] r);
        return TMR_W'({r, 1'b0});
    endfunction

    function automatic logic [TMR_W-1:0] beat_reload(input logic [RDL_W-1:0] l);
        return TMR_W'(l);
    endfunction

endpackage

// File: rtl/sram_bank_decode.sv
module sram_bank_decode
    import sram_ctrl_pkg::*;
#(
    parameter int NBANKS = 6,
    parameter int SEL_W  = 3,
    parameter int WOFF_W = 24
) (
    input  logic [SEL_W+WOFF_W-1:0]      word_addr,
    input  logic [NBANKS-1:0][KIND_W-1:0] cfg_kind,
    input  logic [NBANKS-1:0][RDL_W-1:0]  cfg_rd_lat,
    input  logic [NBANKS-1:0][WRW_W-1:0]  cfg_wr_wid,
    input  logic [NBANKS-1:0][RRR_W-1:0]  cfg_recov,
    input  logic [NBANKS-1:0]             cfg_half_bus,
    output logic [SEL_W-1:0]              bank,
    output bank_timing_t                  timing,
    output logic                          usable
);

    logic [NBANKS-1:0]  hit;
    logic [NBANKS-1:0]  is_sram;
    bank_timing_t       per_bank [NBANKS];

    assign bank = word_addr[SEL_W+WOFF_W-1:WOFF_W];

    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
        assign hit[g]               = (bank == SEL_W'(g));
        assign is_sram[g]           = (cfg_kind[g] == KIND_SRAM);
        assign per_bank[g].rd_lat   = cfg_rd_lat[g];
        assign per_bank[g].wr_wid   = cfg_wr_wid[g];
        assign per_bank[g].recov    = cfg_recov[g];
        assign per_bank[g].half_bus = cfg_half_bus[g];
    end

    always_comb begin
        timing = '0;
        usable = 1'b0;
        for (int i = 0; i < NBANKS; i++) begin
            if (hit[i]) begin
                timing = per_bank[i];
                usable = is_sram[i];
            end
        end
    end

endmodule

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] reload,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_mux.sv
module sram_lane_mux (
    input  logic        half_bus,
    input  logic        upper_half,
    input  logic [31:0] wdata,
    input  logic [3:0]  be,
    output logic [31:0] dq,
    output logic [3:0]  be_n
);

    logic [15:0] hw;
    logic [1:0]  hw_be;

    assign hw    = upper_half ? wdata[31:16] : wdata[15:0];
    assign hw_be = upper_half ? be[3:2] : be[1:0];

    always_comb begin
        if (half_bus) begin
            // all pins driven; only the low lanes reach the memory
            dq   = {hw, hw};
            be_n = {2'b11, ~hw_be};
        end else begin
            dq   = wdata;
            be_n = ~be;
        end
    end

endmodule

// File: rtl/sram_ctrl_top.sv
module sram_ctrl_top
    import sram_ctrl_pkg::*;
#(
    parameter int NBANKS = 6,
    parameter int OFFS_W = 26
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic                                  req_write,
    input  logic [$clog2(NBANKS)+OFFS_W-3:0]      req_addr,
    input  logic [31:0]                           req_wdata,
    input  logic [3:0]                            req_be,
    input  logic [1:0]                            req_len,
    output logic                                  rsp_valid,
    output logic [31:0]                           rsp_rdata,
    output logic                                  rsp_err,
    input  logic [NBANKS-1:0][KIND_W-1:0]         cfg_kind,
    input  logic [NBANKS-1:0][RDL_W-1:0]          cfg_rd_lat,
    input  logic [NBANKS-1:0][WRW_W-1:0]          cfg_wr_wid,
    input  logic [NBANKS-1:0][RRR_W-1:0]          cfg_recov,
    input  logic [NBANKS-1:0]                     cfg_half_bus,
    output logic [NBANKS-1:0]                     mem_cs_n,
    output logic [OFFS_W-1:0]                     mem_addr,
    output logic                                  mem_oe_n,
    output logic                                  mem_we_n,
    output logic [3:0]                            mem_be_n,
    output logic [31:0]                           mem_dq_o,
    output logic                                  mem_dq_oe,
    input  logic [31:0]                           mem_dq_i
);

    localparam int SEL_W  = $clog2(NBANKS);
    localparam int WOFF_W = OFFS_W - 2;

    bus_state_e        state_q, state_d;
    logic [SEL_W-1:0]  bank_q;
    bank_timing_t      tim_q;
    logic [OFFS_W-1:0] addr_q;
    logic [31:0]       wdata_q;
    logic [3:0]        be_q;
    logic [1:0]        words_left_q;
    logic              upper_q;
    logic [15:0]       low_half_q;
    logic              rsp_valid_q;
    logic              rsp_err_q;
    logic [31:0]       rsp_rdata_q;

    logic [SEL_W-1:0]  dec_bank;
    bank_timing_t      dec_tim;
    logic              dec_ok;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;

    logic [31:0]       lane_dq;
    logic [3:0]        lane_be_n;
    logic              on_bus;
    logic              writing;
    logic              more_halves;
    logic [OFFS_W-1:0] step;

    sram_bank_decode #(
        .NBANKS (NBANKS),
        .SEL_W  (SEL_W),
        .WOFF_W (WOFF_W)
    ) i_decode (
        .word_addr    (req_addr),
        .cfg_kind     (cfg_kind),
        .cfg_rd_lat   (cfg_rd_lat),
        .cfg_wr_wid   (cfg_wr_wid),
        .cfg_recov    (cfg_recov),
        .cfg_half_bus (cfg_half_bus),
        .bank         (dec_bank),
        .timing       (dec_tim),
        .usable       (dec_ok)
    );

    sram_cycle_timer #(.W(TMR_W)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .reload  (tmr_val),
        .expired (tmr_expired)
    );

    sram_lane_mux i_lanes (
        .half_bus   (tim_q.half_bus),
        .upper_half (upper_q),
        .wdata      (wdata_q),
        .be         (be_q),
        .dq         (lane_dq),
        .be_n       (lane_be_n)
    );

    assign more_halves = tim_q.half_bus && !upper_q;
    assign step        = tim_q.half_bus ? OFFS_W'(2) : OFFS_W'(4);

    // next state and timer reload
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!dec_ok) begin
                        state_d = ST_REJECT;
                    end else if (req_write) begin
                        state_d  = ST_WSTROBE;
                        tmr_load = 1'b1;
                        tmr_val  = strobe_reload(dec_tim.wr_wid);
                    end else begin
                        state_d  = ST_READ;
                        tmr_load = 1'b1;
                        tmr_val  = beat_reload(dec_tim.rd_lat);
                    end
                end
            end
            ST_REJECT: state_d = ST_IDLE;
            ST_READ: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (!more_halves && words_left_q == 2'd0) begin
                        state_d = ST_RECOVER;
                        tmr_val = recover_reload(tim_q.recov);
                    end else begin
                        tmr_val = beat_reload(tim_q.rd_lat);
                    end
                end
            end
            ST_WSTROBE: begin
                if (tmr_expired) state_d = ST_WHOLD;
            end
            ST_WHOLD: begin
                tmr_load = 1'b1;
                if (more_halves) begin
                    state_d = ST_WSTROBE;
                    tmr_val = strobe_reload(tim_q.wr_wid);
                end else begin
                    state_d = ST_RECOVER;
                    tmr_val = recover_reload(tim_q.recov);
                end
            end
            ST_RECOVER: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            bank_q       <= '0;
            tim_q        <= '0;
            addr_q       <= '0;
            wdata_q      <= '0;
            be_q         <= '0;
            words_left_q <= '0;
            upper_q      <= 1'b0;
            low_half_q   <= '0;
            rsp_valid_q  <= 1'b0;
            rsp_err_q    <= 1'b0;
            rsp_rdata_q  <= '0;
        end else begin
            state_q     <= state_d;
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        bank_q       <= dec_bank;
                        tim_q        <= dec_tim;
                        addr_q       <= {req_addr[WOFF_W-1:0], 2'b00};
                        wdata_q      <= req_wdata;
                        be_q         <= req_be;
                        words_left_q <= req_write ? 2'd0 : req_len;
                        upper_q      <= 1'b0;
                        rsp_err_q    <= !dec_ok;
                    end
                end
                ST_READ: begin
                    if (tmr_expired) begin
                        if (more_halves) begin
                            low_half_q <= mem_dq_i[15:0];
                            upper_q    <= 1'b1;
                            addr_q     <= addr_q + step;
                        end else begin
                            rsp_valid_q <= 1'b1;
                            rsp_rdata_q <= tim_q.half_bus ? {mem_dq_i[15:0], low_half_q}
                                                          : mem_dq_i;
                            upper_q     <= 1'b0;
                            if (words_left_q != 2'd0) begin
                                words_left_q <= words_left_q - 2'd1;
                                addr_q       <= addr_q + step;
                            end
                        end
                    end
                end
                ST_WHOLD: begin
                    if (more_halves) begin
                        upper_q <= 1'b1;
                        addr_q  <= addr_q + step;
                    end
                end
                default: ;
            endcase
        end
    end

    // pin decode
    assign on_bus  = (state_q == ST_READ) || (state_q == ST_WSTROBE) || (state_q == ST_WHOLD);
    assign writing = (state_q == ST_WSTROBE) || (state_q == ST_WHOLD);

    always_comb begin
        mem_cs_n = '1;
        for (int i = 0; i < NBANKS; i++) begin
            if (on_bus && bank_q == SEL_W'(i)) mem_cs_n[i] = 1'b0;
        end
    end

    always_comb begin
        if (state_q == ST_READ) mem_be_n = 4'b0000;
        else if (writing)       mem_be_n = lane_be_n;
        else                    mem_be_n = 4'b1111;
    end

    assign mem_addr  = addr_q;
    assign mem_oe_n  = (state_q != ST_READ);
    assign mem_we_n  = (state_q != ST_WSTROBE);
    assign mem_dq_oe = writing;
    assign mem_dq_o  = writing ? lane_dq : '0;
    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;
    assign rsp_err   = rsp_err_q;

    // properties guarding the pin rules
    p_single_cs_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(~mem_cs_n) <= 1);

    p_enable_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    p_enable_needs_cs_r3: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1));

    p_read_strobes_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_be_n == 4'b0000));

    p_write_drives_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe);

    p_we_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && state_d != ST_WSTROBE) |=> (mem_we_n && mem_cs_n != '1));

    p_gap_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_cs_n == '1) |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_err_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_err |=> (!rsp_err && req_ready));

    p_err_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (mem_cs_n == '1));

    p_rsp_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && rsp_err));

    p_idle_pins_r12: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n == '1 && mem_be_n == 4'b1111));

endmodule

// File: tb/test_sram_ctrl_top.sv
module test_sram_ctrl_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [26:0]       req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [3:0]        req_be = '0;
    logic [1:0]        req_len = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              rsp_err;
    logic [NB-1:0][2:0] cfg_kind;
    logic [NB-1:0][3:0] cfg_rd_lat;
    logic [NB-1:0][3:0] cfg_wr_wid;
    logic [NB-1:0][2:0] cfg_recov;
    logic [NB-1:0]      cfg_half_bus;
    logic [NB-1:0]      mem_cs_n;
    logic [25:0]        mem_addr;
    logic               mem_oe_n;
    logic               mem_we_n;
    logic [3:0]         mem_be_n;
    logic [31:0]        mem_dq_o;
    logic               mem_dq_oe;
    logic [31:0]        mem_dq_i;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sram_ctrl_top i_sram_ctrl_top (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_be       (req_be),
        .req_len      (req_len),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .rsp_err      (rsp_err),
        .cfg_kind     (cfg_kind),
        .cfg_rd_lat   (cfg_rd_lat),
        .cfg_wr_wid   (cfg_wr_wid),
        .cfg_recov    (cfg_recov),
        .cfg_half_bus (cfg_half_bus),
        .mem_cs_n     (mem_cs_n),
        .mem_addr     (mem_addr),
        .mem_oe_n     (mem_oe_n),
        .mem_we_n     (mem_we_n),
        .mem_be_n     (mem_be_n),
        .mem_dq_o     (mem_dq_o),
        .mem_dq_oe    (mem_dq_oe),
        .mem_dq_i     (mem_dq_i)
    );

    // bench configuration
    int b_kind [NB] = '{1, 1, 2, 1, 0, 7};
    int b_rdl  [NB] = '{2, 1, 1, 0, 1, 1};
    int b_wrw  [NB] = '{3, 0, 1, 1, 1, 1};
    int b_rrr  [NB] = '{1, 0, 1, 2, 1, 1};
    bit b_half [NB] = '{0, 1, 0, 0, 0, 0};

    initial begin
        for (int i = 0; i < NB; i++) begin
            cfg_kind[i]     = 3'(b_kind[i]);
            cfg_rd_lat[i]   = 4'(b_rdl[i]);
            cfg_wr_wid[i]   = 4'(b_wrw[i]);
            cfg_recov[i]    = 3'(b_rrr[i]);
            cfg_half_bus[i] = b_half[i];
        end
    end

    function automatic logic [7:0] pattern(input int b, input int i);
        return 8'(b * 16 + i * 7 + 3);
    endfunction

    // memory model: bytes per bank, little-endian lanes
    logic [7:0] sram   [NB][256];
    logic [7:0] shadow [NB][256];

    always_comb begin
        mem_dq_i = 32'hDEAD_BEEF;
        for (int b = 0; b < NB; b++) begin
            if (!mem_cs_n[b] && !mem_oe_n) begin
                if (b_half[b])
                    mem_dq_i = {16'hDEAD, sram[b][8'(mem_addr[7:0] + 8'd1)], sram[b][mem_addr[7:0]]};
                else
                    mem_dq_i = {sram[b][8'(mem_addr[7:0] + 8'd3)], sram[b][8'(mem_addr[7:0] + 8'd2)],
                                sram[b][8'(mem_addr[7:0] + 8'd1)], sram[b][mem_addr[7:0]]};
            end
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NB; b++)
                for (int i = 0; i < 256; i++) sram[b][i] <= pattern(b, i);
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (!mem_cs_n[b] && !mem_we_n) begin
                    for (int l = 0; l < (b_half[b] ? 2 : 4); l++)
                        if (!mem_be_n[l]) sram[b][8'(mem_addr[7:0] + 8'(l))] <= mem_dq_o[8*l +: 8];
                end
            end
        end
    end

    // checking infrastructure
    int n_checks = 0;
    int n_fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        bit          err;
        logic [31:0] data;
        string       tag;
    } rsp_item_t;

    rsp_item_t sb_q [$];

    // expectations set by the driver
    int         exp_bank    = 0;
    int         exp_oe_run  = 0;
    int         exp_we_run  = 0;
    int         exp_gap     = 0;
    logic [3:0] exp_be [2];
    int         cs_cycles   = 0;
    int         stray       = 0;
    int         oe_run      = 0;
    int         we_run      = 0;
    int         we_idx      = 0;
    int         gap         = 0;
    bit         gap_on      = 1'b0;
    bit         cs_low_prev = 1'b0;

    // monitor: samples on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_oe_n) begin
                oe_run++;
                check(mem_be_n == 4'b0000, "R4", "read strobes", 32'(mem_be_n), 0);
            end else if (oe_run != 0) begin
                check(oe_run == exp_oe_run, "R6", "oe low run", oe_run, exp_oe_run);
                oe_run = 0;
            end
            if (!mem_we_n) begin
                we_run++;
                check(mem_be_n == exp_be[we_idx % 2], "R5", "write strobes",
                      32'(mem_be_n), 32'(exp_be[we_idx % 2]));
                check(mem_dq_oe == 1'b1, "R5", "data driven", 32'(mem_dq_oe), 1);
            end else if (we_run != 0) begin
                check(we_run == exp_we_run, "R7", "we low run", we_run, exp_we_run);
                check(mem_cs_n != '1, "R7", "cs held after strobe", 32'(mem_cs_n), 0);
                we_run = 0;
                we_idx++;
            end
            if (!mem_oe_n && !mem_we_n)
                check(1'b0, "R3", "oe and we both low", 0, 1);
            if (exp_bank < NB && mem_cs_n == ~(NB'(1) << exp_bank)) cs_cycles++;
            else if (mem_cs_n != '1) stray++;

            if (mem_cs_n == '1 && cs_low_prev) begin
                gap = 1;
                gap_on = 1'b1;
            end else if (gap_on && req_ready) begin
                check(gap == exp_gap, "R8", "recovery gap", gap, exp_gap);
                gap_on = 1'b0;
            end else if (gap_on) begin
                gap++;
            end
            cs_low_prev = (mem_cs_n != '1);

            if (rsp_valid || rsp_err) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected response", rsp_rdata, 0);
                end else begin
                    rsp_item_t it;
                    it = sb_q.pop_front();
                    check(rsp_err == it.err, it.tag, "response kind", 32'(rsp_err), 32'(it.err));
                    if (!it.err)
                        check(rsp_rdata == it.data, it.tag, "read data", rsp_rdata, it.data);
                end
            end
        end
    end

    // driver: called on a falling edge with the controller idle
    task automatic do_req(input bit wr, input int bank, input int off, input logic [31:0] wd,
                          input logic [3:0] be, input int len, input string tag);
        bit ok;
        int h, w, busy, exp_busy, exp_cs;
        ok = (bank < NB) && (b_kind[bank] == 1);
        exp_bank = bank;
        if (!ok) begin
            rsp_item_t e;
            e.err = 1'b1; e.data = '0; e.tag = tag;
            sb_q.push_back(e);
            exp_busy = 1;
            exp_cs   = 0;
        end else begin
            h = b_half[bank] ? 2 : 1;
            w = (b_wrw[bank] == 0) ? 1 : b_wrw[bank];
            exp_gap = 2 * b_rrr[bank] + 1;
            if (wr) begin
                exp_we_run = w;
                if (b_half[bank]) begin
                    exp_be[0] = {2'b11, ~be[1:0]};
                    exp_be[1] = {2'b11, ~be[3:2]};
                end else begin
                    exp_be[0] = ~be;
                    exp_be[1] = ~be;
                end
                for (int j = 0; j < 4; j++)
                    if (be[j]) shadow[bank][off + j] = wd[8*j +: 8];
                exp_cs   = h * (w + 1);
                exp_busy = exp_cs + exp_gap;
            end else begin
                for (int k = 0; k <= len; k++) begin
                    rsp_item_t r;
                    r.err = 1'b0; r.tag = tag;
                    for (int j = 0; j < 4; j++) r.data[8*j +: 8] = shadow[bank][off + 4*k + j];
                    sb_q.push_back(r);
                end
                exp_cs     = (len + 1) * h * (b_rdl[bank] + 1);
                exp_oe_run = exp_cs;
                exp_busy   = exp_cs + exp_gap;
            end
        end
        cs_cycles = 0;
        stray     = 0;
        we_idx    = 0;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {3'(bank), 24'(off / 4)};
        req_wdata = wd;
        req_be    = be;
        req_len   = 2'(len);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        while (!req_ready) begin
            busy++;
            @(negedge clk);
        end
        check(busy == exp_busy, "R9", {tag, " busy cycles"}, busy, exp_busy);
        check(cs_cycles == exp_cs, "R1", {tag, " selected cs cycles"}, cs_cycles, exp_cs);
        check(stray == 0, "R1", {tag, " other cs low"}, stray, 0);
        @(negedge clk);
    endtask

    bit done = 1'b0;

    initial begin
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < 256; i++) shadow[b][i] = pattern(b, i);
        repeat (4) @(posedge clk);
        // R12: pins while reset is held
        @(negedge clk);
        check(mem_cs_n == '1 && mem_oe_n && mem_we_n, "R12", "reset enables", 32'(mem_cs_n), 32'h3f);
        check(mem_be_n == 4'b1111 && !mem_dq_oe && !rsp_valid, "R12", "reset strobes", 32'(mem_be_n), 32'hf);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R12", "ready after reset", 32'(req_ready), 1);

        do_req(0, 0, 16'h10, '0, '0, 0, "R6");
        do_req(1, 0, 16'h20, 32'hA1B2C3D4, 4'b1111, 0, "R5");
        do_req(1, 0, 16'h28, 32'h11223344, 4'b1111, 0, "R7");
        do_req(0, 0, 16'h20, '0, '0, 3, "R10");
        do_req(1, 0, 16'h24, 32'h55667788, 4'b0101, 0, "R5");
        do_req(0, 0, 16'h24, '0, '0, 0, "R5");
        do_req(0, 1, 16'h40, '0, '0, 1, "R11");
        do_req(1, 1, 16'h44, 32'hCAFEF00D, 4'b1111, 0, "R11");
        do_req(1, 1, 16'h48, 32'h9ABCDEF0, 4'b0110, 0, "R11");
        do_req(0, 1, 16'h44, '0, '0, 1, "R11");
        do_req(1, 3, 16'h80, 32'h0BADCAFE, 4'b1000, 0, "R8");
        do_req(0, 3, 16'h80, '0, '0, 2, "R8");
        do_req(1, 2, 16'h30, 32'hFFFFFFFF, 4'b1111, 0, "R2");
        do_req(0, 2, 16'h30, '0, '0, 0, "R2");
        do_req(1, 4, 16'h30, 32'hFFFFFFFF, 4'b1111, 0, "R2");
        do_req(0, 5, 16'h30, '0, '0, 0, "R2");
        do_req(1, 6, 16'h30, 32'hFFFFFFFF, 4'b1111, 0, "R1");
        do_req(0, 7, 16'h30, '0, '0, 1, "R1");
        // R2: rejected writes left the memory untouched
        for (int b = 2; b < NB; b++)
            for (int j = 0; j < 4; j++)
                check(sram[b][16'h30 + j] == pattern(b, 16'h30 + j), "R2", "memory untouched",
                      32'(sram[b][16'h30 + j]), 32'(pattern(b, 16'h30 + j)));
        check(sb_q.size() == 0, "R10", "all responses seen", sb_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R9 actual=hung expected=idle");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule